// File: doc/BRIEF.md
# UART Modem Loopback Mapper

This block sits beside the register file of a UART and handles its internal loopback path. A loopback-enable field in the control register switches it on. While it is on, the software-driven modem outputs (Out1, Out2, RTS, DTR) are reflected back onto the modem status flags through a fixed cross-mapping. Each control write also produces a set of interrupt clear and set requests, so the modem-status interrupt bits follow the new flags.

Loopback works at the character level. Every transmit data write is copied to the receive buffer push port. A rising break bit pushes a break-flagged entry. Characters that arrive from the external receive path are dropped. When loopback is off, the modem flags follow the external modem pins through a configurable synchronizer. In that mode external characters go to the push port and transmit writes do not.

Every output is registered, so each response appears one clock after the write that causes it. Writes that software makes to the flag register are ignored.

Top module: `uart_lb_mapper`

## Requirements
- R1: After a synchronous reset, loopback is off, `modem_flags` is 0 (with the external pins low), and `rx_push_valid`, `ms_irq_set` and `ms_irq_clr` are all 0.
- R2: One cycle after a control write with `ctrl_lbe`=1, `modem_flags` is updated with the following mapping: bit 0 (ring indicator) = Out2, bit 1 (clear-to-send) = RTS, bit 2 (carrier detect) = Out1, bit 3 (data-set-ready) = DTR.
- R3: The mapping is applied by any control write with `ctrl_lbe`=1. This includes the write that first turns loopback on while the other fields keep their values. While loopback stays on, `modem_flags` holds and ignores the external pins.
- R4: In the cycle after a control write with `ctrl_lbe`=1, `ms_irq_clr` is 4'hF and `ms_irq_set` equals the new `modem_flags`, using the same bit positions. In every other cycle both are 0.
- R5: With loopback on, a transmit write makes `rx_push_valid`=1 one cycle later, with `rx_push_data` equal to the written value and `rx_push_brk`=0.
- R6: With loopback on, a line-control write that takes the break bit from 0 to 1 pushes one entry with `rx_push_brk`=1 and data 0. A write that keeps the bit at 1 or clears it pushes nothing.
- R7: With loopback on, external receive characters are discarded. With loopback off, each one is pushed one cycle later with its data and `rx_push_brk`=0.
- R8: With loopback off, transmit writes and break rises push nothing.
- R9: Writes to the flag register (`flag_wr`) have no effect on `modem_flags`.
- R10: With loopback off, `modem_flags` follows the external pins (`ext_ri`, `ext_cts`, `ext_dcd`, `ext_dsr` in bits 0 to 3) after `SYNC_STAGES`+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_lbe | input | 1 | Loopback enable field of the control write |
| ctrl_out1 | input | 1 | Out1 field of the control write |
| ctrl_out2 | input | 1 | Out2 field of the control write |
| ctrl_rts | input | 1 | RTS field of the control write |
| ctrl_dtr | input | 1 | DTR field of the control write |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmit data value |
| lcr_wr | input | 1 | Line control write strobe |
| lcr_brk | input | 1 | Break bit of the line control write |
| flag_wr | input | 1 | Write strobe to the read-only flag register |
| ext_rx_valid | input | 1 | Character arriving from the external receive path |
| ext_rx_data | input | DATA_W | External receive character |
| ext_ri | input | 1 | External ring indicator pin |
| ext_dcd | input | 1 | External carrier detect pin |
| ext_cts | input | 1 | External clear-to-send pin |
| ext_dsr | input | 1 | External data-set-ready pin |
| modem_flags | output | 4 | Modem status flags {DSR, DCD, CTS, RI} |
| ms_irq_set | output | 4 | Modem interrupt set request, same bit order |
| ms_irq_clr | output | 4 | Modem interrupt clear request, same bit order |
| rx_push_valid | output | 1 | Receive buffer push strobe |
| rx_push_data | output | DATA_W | Pushed character |
| rx_push_brk | output | 1 | Pushed entry is a break |

## Verification
The assertions assume a register interface that makes at most one register write per clock. At most one of `ctrl_wr`, `tx_wr`, `lcr_wr` and `flag_wr` is high in any cycle, so a transmit write and a break rise never compete for the push port. The stimulus selects one operation per cycle at random, drives it for one clock and releases it, so it stays within this assumption. An external receive character can still arrive in the same cycle as a register write, and the bench does produce that overlap.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    localparam int MS_W = 4;

    // bit 3..0 = dsr, dcd, cts, ri
    typedef struct packed {
        logic dsr;
        logic dcd;
        logic cts;
        logic ri;
    } modem_t;

    typedef struct packed {
        logic lbe;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TX   = 2'd1,
        SRC_BRK  = 2'd2,
        SRC_EXT  = 2'd3
    } rx_src_e;

    function automatic modem_t loop_map(input ctrl_t c);
        modem_t m;
        m.ri  = c.out2;
        m.dcd = c.out1;
        m.cts = c.rts;
        m.dsr = c.dtr;
        return m;
    endfunction

endpackage

// File: rtl/uart_lb_mode.sv
module uart_lb_mode (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic ctrl_lbe,
    input  logic lcr_wr,
    input  logic lcr_brk,
    output logic lbe_q,
    output logic brk_rise
);
    logic brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lbe_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            if (ctrl_wr) lbe_q <= ctrl_lbe;
            if (lcr_wr)  brk_q <= lcr_brk;
        end
    end

    // break only diverted into receive path while looping back
    assign brk_rise = lcr_wr && lcr_brk && !brk_q && lbe_q;

    // R6: a second break-on write without an intervening clear never rises
    p_brk_once_r6: assert property (@(posedge clk) disable iff (rst)
        brk_rise |=> !(lcr_wr && lcr_brk && !ctrl_wr && brk_rise));

endmodule

// File: rtl/uart_lb_modem.sv
module uart_lb_modem
    import uart_lb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  ctrl_t            wr_ctrl,
    input  logic             lbe_q,
    input  logic             flag_wr,
    input  modem_t           ext_pins,
    output modem_t           flags,
    output logic [MS_W-1:0]  irq_set,
    output logic [MS_W-1:0]  irq_clr
);
    modem_t pins_s;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign pins_s = ext_pins;
        end else begin : g_sync
            modem_t chain [SYNC_STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
                end else begin
                    chain[0] <= ext_pins;
                    for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
                end
            end
            assign pins_s = chain[SYNC_STAGES-1];
        end
    endgenerate

    logic   map_now;
    modem_t mapped;

    assign map_now = ctrl_wr && wr_ctrl.lbe;
    assign mapped  = loop_map(wr_ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            irq_set <= '0;
            irq_clr <= '0;
        end else begin
            irq_set <= '0;
            irq_clr <= '0;
            if (map_now) begin
                flags   <= mapped;
                irq_clr <= '1;
                irq_set <= mapped;
            end else if (ctrl_wr || !lbe_q) begin
                flags <= pins_s;
            end
        end
    end

    // R2: each control output lands on its own status bit
    p_ri_out2_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_ctrl.lbe) |=> (flags.ri == $past(wr_ctrl.out2)));
    p_dsr_dtr_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_ctrl.lbe) |=> (flags.dsr == $past(wr_ctrl.dtr)));
    // R3: flags hold while loopback stays on
    p_hold_lb_r3: assert property (@(posedge clk) disable iff (rst)
        (lbe_q && !ctrl_wr) |=> $stable(flags));
    // R4: set requests only travel with a full clear
    p_set_with_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_set != '0) |-> (irq_clr == '1));
    p_clr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_clr != '0) |=> (irq_clr == '0) || $past(ctrl_wr));
    // R9: flag register writes leave flags alone in loopback
    p_flag_wr_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && lbe_q && !ctrl_wr) |=> $stable(flags));

endmodule

// File: rtl/uart_lb_route.sv
module uart_lb_route
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lbe_q,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              brk_rise,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_data,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_brk
);
    rx_src_e src;

    always_comb begin
        src = SRC_NONE;
        if (lbe_q) begin
            if (tx_wr)         src = SRC_TX;
            else if (brk_rise) src = SRC_BRK;
        end else if (ext_valid) begin
            src = SRC_EXT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_valid <= 1'b0;
            push_data  <= '0;
            push_brk   <= 1'b0;
        end else begin
            push_valid <= (src != SRC_NONE);
            push_brk   <= (src == SRC_BRK);
            unique case (src)
                SRC_TX:  push_data <= tx_data;
                SRC_EXT: push_data <= ext_data;
                default: push_data <= '0;
            endcase
        end
    end

    // R5: transmit write is echoed unchanged
    p_tx_echo_r5: assert property (@(posedge clk) disable iff (rst)
        (lbe_q && tx_wr) |=> (push_valid && !push_brk && push_data == $past(tx_data)));
    // R7: external input is dropped while looping back
    p_ext_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (lbe_q && !tx_wr && !brk_rise) |=> !push_valid);
    // R8: loopback off never echoes transmit data
    p_no_echo_off_r8: assert property (@(posedge clk) disable iff (rst)
        (!lbe_q && !ext_valid) |=> !push_valid);

endmodule

// File: rtl/uart_lb_mapper.sv
module uart_lb_mapper
    import uart_lb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              ctrl_lbe,
    input  logic              ctrl_out1,
    input  logic              ctrl_out2,
    input  logic              ctrl_rts,
    input  logic              ctrl_dtr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              lcr_wr,
    input  logic              lcr_brk,
    input  logic              flag_wr,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_ri,
    input  logic              ext_dcd,
    input  logic              ext_cts,
    input  logic              ext_dsr,
    output logic [3:0]        modem_flags,
    output logic [3:0]        ms_irq_set,
    output logic [3:0]        ms_irq_clr,
    output logic              rx_push_valid,
    output logic [DATA_W-1:0] rx_push_data,
    output logic              rx_push_brk
);
    logic   lbe_q;
    logic   brk_rise;
    ctrl_t  wr_ctrl;
    modem_t pins;
    modem_t flags;

    assign wr_ctrl = '{lbe: ctrl_lbe, out2: ctrl_out2, out1: ctrl_out1,
                       rts: ctrl_rts, dtr: ctrl_dtr};
    assign pins    = '{dsr: ext_dsr, dcd: ext_dcd, cts: ext_cts, ri: ext_ri};

    uart_lb_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .ctrl_lbe (ctrl_lbe),
        .lcr_wr   (lcr_wr),
        .lcr_brk  (lcr_brk),
        .lbe_q    (lbe_q),
        .brk_rise (brk_rise)
    );

    uart_lb_modem #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wr_ctrl  (wr_ctrl),
        .lbe_q    (lbe_q),
        .flag_wr  (flag_wr),
        .ext_pins (pins),
        .flags    (flags),
        .irq_set  (ms_irq_set),
        .irq_clr  (ms_irq_clr)
    );

    assign modem_flags = flags;

    uart_lb_route #(.DATA_W(DATA_W)) u_route (
        .clk        (clk),
        .rst        (rst),
        .lbe_q      (lbe_q),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .brk_rise   (brk_rise),
        .ext_valid  (ext_rx_valid),
        .ext_data   (ext_rx_data),
        .push_valid (rx_push_valid),
        .push_data  (rx_push_data),
        .push_brk   (rx_push_brk)
    );

    // input assumption: one register write per clock
    p_one_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_wr, tx_wr, lcr_wr, flag_wr}));
    // R6: a break entry always carries zero data
    p_brk_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rx_push_brk |-> (rx_push_valid && rx_push_data == '0));
    // R1: nothing is pushed right after reset
    p_quiet_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!rx_push_valid && ms_irq_clr == '0));

endmodule

// File: tb/sim_uart_lb_mapper.sv
module sim_uart_lb_mapper;
    localparam int DW = 8;
    localparam int SY = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_wr = 0, ctrl_lbe = 0, ctrl_out1 = 0, ctrl_out2 = 0, ctrl_rts = 0, ctrl_dtr = 0;
    logic tx_wr = 0, lcr_wr = 0, lcr_brk = 0, flag_wr = 0, ext_rx_valid = 0;
    logic [DW-1:0] tx_data = '0, ext_rx_data = '0;
    logic ext_ri = 0, ext_dcd = 0, ext_cts = 0, ext_dsr = 0;
    logic [3:0] modem_flags, ms_irq_set, ms_irq_clr;
    logic rx_push_valid, rx_push_brk;
    logic [DW-1:0] rx_push_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    bit       m_lbe = 0;
    bit       m_brk = 0;
    bit [3:0] m_flags = 4'h0;

    always #5 clk = ~clk;

    uart_lb_mapper #(.DATA_W(DW), .SYNC_STAGES(SY)) u0 (.*);

    function automatic bit [3:0] exp_map(bit o1, bit o2, bit rts, bit dtr);
        return {dtr, o1, rts, o2};
    endfunction

    function automatic bit [3:0] pin_vec();
        return {ext_dsr, ext_dcd, ext_cts, ext_ri};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_push(string req, bit v, bit [DW-1:0] d, bit b);
        chk(req, {rx_push_valid, rx_push_brk, rx_push_data}, {v, b, v ? d : {DW{1'b0}}});
        chk(req, {ms_irq_set, ms_irq_clr}, 8'h00);
    endtask

    task automatic do_ctrl(bit lbe, bit o1, bit o2, bit rts, bit dtr, string req);
        ctrl_wr = 1; ctrl_lbe = lbe; ctrl_out1 = o1; ctrl_out2 = o2; ctrl_rts = rts; ctrl_dtr = dtr;
        @(negedge clk);
        ctrl_wr = 0;
        m_lbe = lbe;
        if (lbe) begin
            m_flags = exp_map(o1, o2, rts, dtr);
            chk(req, modem_flags, m_flags);
            chk("R4", ms_irq_clr, 4'hF);
            chk("R4", ms_irq_set, m_flags);
        end else begin
            chk("R4", {ms_irq_set, ms_irq_clr}, 8'h00);
        end
        @(negedge clk);
        chk("R4", {ms_irq_set, ms_irq_clr}, 8'h00);
        if (!lbe) begin
            repeat (SY + 1) @(negedge clk);
            m_flags = pin_vec();
            chk("R10", modem_flags, m_flags);
        end
    endtask

    task automatic do_tx(bit [DW-1:0] d);
        tx_wr = 1; tx_data = d;
        @(negedge clk);
        tx_wr = 0;
        chk_push(m_lbe ? "R5" : "R8", m_lbe, d, 1'b0);
    endtask

    task automatic do_lcr(bit b);
        bit rise;
        rise = b && !m_brk && m_lbe;
        lcr_wr = 1; lcr_brk = b;
        @(negedge clk);
        lcr_wr = 0;
        m_brk = b;
        chk_push(m_lbe ? "R6" : "R8", rise, '0, rise);
    endtask

    task automatic do_rx(bit [DW-1:0] d);
        ext_rx_valid = 1; ext_rx_data = d;
        @(negedge clk);
        ext_rx_valid = 0;
        chk_push("R7", !m_lbe, d, 1'b0);
    endtask

    task automatic do_flag();
        flag_wr = 1;
        @(negedge clk);
        flag_wr = 0;
        chk("R9", modem_flags, m_flags);
    endtask

    task automatic set_pins(bit [3:0] p);
        {ext_dsr, ext_dcd, ext_cts, ext_ri} = p;
        repeat (SY + 2) @(negedge clk);
        if (!m_lbe) m_flags = p;
        chk(m_lbe ? "R3" : "R10", modem_flags, m_flags);
    endtask

    initial begin
        bit [31:0] r;
        r = $urandom(32'd20250611);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", modem_flags, 4'h0);
        chk_push("R1", 1'b0, '0, 1'b0);

        // R10 pins through synchronizer, then R7/R8 with loopback off
        set_pins(4'b1010);
        set_pins(4'b0101);
        do_rx(8'hA5);
        do_tx(8'h3C);
        do_lcr(1);
        do_lcr(0);

        // R2 mapping, distinct patterns
        do_ctrl(1, 1, 0, 0, 0, "R2");
        do_ctrl(1, 0, 1, 0, 0, "R2");
        do_ctrl(1, 0, 0, 1, 0, "R2");
        do_ctrl(1, 0, 0, 0, 1, "R2");
        do_ctrl(1, 1, 1, 1, 1, "R2");
        // R3 pins ignored while on; write that only flips lbe on
        set_pins(4'b0000);
        do_ctrl(0, 1, 0, 1, 0, "R3");
        do_ctrl(1, 1, 0, 1, 0, "R3");
        do_flag();
        // R5/R6/R7 loopback on
        do_tx(8'h00);
        do_tx(8'hFF);
        do_rx(8'h77);
        do_lcr(1);
        do_lcr(1);
        do_lcr(0);
        do_lcr(1);
        do_lcr(0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            r = $urandom;
            case (r % 7)
                0: do_ctrl((r[8:3] != 0), r[9], r[10], r[11], r[12], "R2");
                1: do_tx(r[23:16]);
                2: do_lcr(r[4]);
                3: do_rx(r[23:16]);
                4: do_flag();
                5: set_pins(r[7:4]);
                default: begin
                    // overlap of external character with a transmit write
                    tx_wr = 1; tx_data = r[15:8];
                    ext_rx_valid = 1; ext_rx_data = r[23:16];
                    @(negedge clk);
                    tx_wr = 0; ext_rx_valid = 0;
                    chk_push(m_lbe ? "R5" : "R7", 1'b1, m_lbe ? r[15:8] : r[23:16], 1'b0);
                end
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule